// File: doc/BRIEF.md
# Segmented Data Address Generator

This block works out the effective data address for one memory operand of a CPU with 16-bit words. The CPU addresses words, and its address space is 22 bits wide: 64 pages of 64K words each, numbered 0x00 to 0x3F. The decode stage supplies several inputs: the 3-bit addressing-mode field, the 3-bit sub-field, the 6-bit immediate, the optional word that follows the instruction, the base pointer, the selected source register and the status register. From these the block returns three things: the 22-bit word address, the value the source register should take next, and a write-back enable for that register.

A data-segment qualifier on indirect accesses takes the page number from bits 15:10 of the status register and places it above the 16-bit pointer. Every other memory mode goes to page 0. Indirect accesses can step the pointer by one, before or after the access. The stepped value wraps within 16 bits and never carries into the page.

The outputs sit behind one register stage by default. A parameter removes that stage and makes the path purely combinational.

Top module: `seg_data_agen`

## Requirements
- R1: Mode 3 with sub-field 0 addresses the source pointer unchanged on page 0. `ptr_we` is 0 and `ptr_next` equals `src_ptr`.
- R2: Mode 3 with sub-field 1 (post-decrement) addresses the old pointer. `ptr_next` is the pointer minus 1 and `ptr_we` is 1.
- R3: Mode 3 with sub-field 2 (post-increment) addresses the old pointer. `ptr_next` is the pointer plus 1 and `ptr_we` is 1.
- R4: Mode 3 with sub-field 3 (pre-increment) addresses the pointer plus 1. `ptr_next` holds that same value and `ptr_we` is 1.
- R5: In mode 3, sub-fields 4 to 7 behave like sub-fields 0 to 3 for the pointer. The address bits 21:16 come from `stat_reg[15:10]`.
- R6: Every memory mode except mode 3 with sub-field 4 to 7 drives address bits 21:16 to zero, whatever `stat_reg` holds.
- R7: Mode 0 addresses `base_ptr` plus the zero-extended 6-bit immediate, wrapping within 16 bits, on page 0.
- R8: Mode 7 addresses the zero-extended 6-bit immediate on page 0.
- R9: Mode 4 with sub-field 2 or 3 addresses `ext_word` on page 0. Mode 4 with any other sub-field is not a memory access.
- R10: Pointer steps wrap within 16 bits: 0xFFFF+1 gives 0x0000 and 0x0000-1 gives 0xFFFF. The page bits are never changed by a step.
- R11: Modes 1, 2, 5 and 6, and mode 4 with a sub-field other than 2 or 3, give `mem_req`=0, `mem_addr`=0, `ptr_we`=0 and `ptr_next`=`src_ptr`. `mem_req` is 1 for every memory access.
- R12: With the default register stage, the outputs follow the inputs one rising clock edge later. Reset drives all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 3 | Addressing-mode field of the instruction |
| sub_sel | input | 3 | Sub-field qualifying the mode |
| imm6 | input | 6 | 6-bit immediate of the instruction |
| ext_word | input | 16 | Word following the instruction |
| base_ptr | input | 16 | Current base pointer |
| src_ptr | input | 16 | Current value of the source pointer register |
| stat_reg | input | 16 | Status register; bits 15:10 hold the data segment |
| mem_addr | output | 22 | Effective word address |
| ptr_next | output | 16 | Value to write back to the source register |
| ptr_we | output | 1 | Write-back enable for the source register |
| mem_req | output | 1 | The operand is a memory access |

## Verification
The bench puts the pointer at 0xFFFF and 0x0000 with a non-zero segment, so a step that carried into the page bits would show up as a wrong page. It sets the segment to all ones in unqualified modes, where a design that leaked the segment would land off page 0. Pre-increment and post-increment are run on the same kind of pointer; swapping them would put the address one word off while `ptr_next` still matched. The bench also samples just before the clock edge, so an output stage that was missing or doubled would show the wrong cycle.

// File: rtl/dag_pkg.sv
package dag_pkg;

   typedef enum logic [2:0] {
      AM_BASE_OFS = 3'd0,
      AM_IMM6     = 3'd1,
      AM_STACK    = 3'd2,
      AM_PTR      = 3'd3,
      AM_EXT      = 3'd4,
      AM_SHIFT    = 3'd5,
      AM_ROT      = 3'd6,
      AM_DIRECT   = 3'd7
   } amode_e;

   typedef enum logic [1:0] {
      PS_HOLD    = 2'd0,
      PS_POSTDEC = 2'd1,
      PS_POSTINC = 2'd2,
      PS_PREINC  = 2'd3
   } pstep_e;

   localparam logic [2:0] EXT_LOAD  = 3'd2;
   localparam logic [2:0] EXT_STORE = 3'd3;

endpackage

// File: rtl/dag_ptr_step.sv
module dag_ptr_step
   import dag_pkg::*;
#(
   parameter int PTR_W = 16
) (
   input  pstep_e             step_i,
   input  logic [PTR_W-1:0]   ptr_i,
   output logic [PTR_W-1:0]   ea_o,
   output logic [PTR_W-1:0]   next_o,
   output logic               modify_o
);

   localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

   logic [PTR_W-1:0] inc_w;
   logic [PTR_W-1:0] dec_w;

   assign inc_w = ptr_i + ONE;
   assign dec_w = ptr_i - ONE;

   always_comb begin
      ea_o     = ptr_i;
      next_o   = ptr_i;
      modify_o = 1'b0;
      unique case (step_i)
         PS_HOLD: begin
            ea_o = ptr_i;
         end
         PS_POSTDEC: begin
            next_o   = dec_w;
            modify_o = 1'b1;
         end
         PS_POSTINC: begin
            next_o   = inc_w;
            modify_o = 1'b1;
         end
         PS_PREINC: begin
            ea_o     = inc_w;
            next_o   = inc_w;
            modify_o = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/dag_offset_sel.sv
module dag_offset_sel
   import dag_pkg::*;
#(
   parameter int PTR_W = 16,
   parameter int IMM_W = 6
) (
   input  amode_e             mode_i,
   input  logic [2:0]         sub_i,
   input  logic [IMM_W-1:0]   imm_i,
   input  logic [PTR_W-1:0]   ext_i,
   input  logic [PTR_W-1:0]   bp_i,
   input  logic [PTR_W-1:0]   ptr_ea_i,
   output logic [PTR_W-1:0]   ofs_o,
   output logic               mem_o,
   output logic               seg_o,
   output logic               ptr_mode_o
);

   logic [PTR_W-1:0] imm_zx;
   logic [PTR_W-1:0] bp_sum;

   assign imm_zx = PTR_W'(imm_i);
   assign bp_sum = bp_i + imm_zx;

   always_comb begin
      ofs_o      = '0;
      mem_o      = 1'b0;
      seg_o      = 1'b0;
      ptr_mode_o = 1'b0;
      unique case (mode_i)
         AM_BASE_OFS: begin
            ofs_o = bp_sum;
            mem_o = 1'b1;
         end
         AM_PTR: begin
            ofs_o      = ptr_ea_i;
            mem_o      = 1'b1;
            seg_o      = sub_i[2];
            ptr_mode_o = 1'b1;
         end
         AM_EXT: begin
            if (sub_i == EXT_LOAD || sub_i == EXT_STORE) begin
               ofs_o = ext_i;
               mem_o = 1'b1;
            end
         end
         AM_DIRECT: begin
            ofs_o = imm_zx;
            mem_o = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/dag_page_merge.sv
module dag_page_merge #(
   parameter int PTR_W  = 16,
   parameter int PAGE_W = 6,
   parameter int WORD_W = 16,
   parameter int DS_LSB = 10
) (
   input  logic                      seg_i,
   input  logic                      mem_i,
   input  logic [WORD_W-1:0]         stat_i,
   input  logic [PTR_W-1:0]          ofs_i,
   output logic [PTR_W+PAGE_W-1:0]   addr_o
);

   localparam int ADDR_W = PTR_W + PAGE_W;

   logic [PAGE_W-1:0] page_w;

   generate
      if (DS_LSB + PAGE_W > WORD_W) begin : g_bad_ds
         $error("dag_page_merge: segment field exceeds status word");
      end
   endgenerate

   assign page_w = seg_i ? stat_i[DS_LSB +: PAGE_W] : '0;
   assign addr_o = mem_i ? {page_w, ofs_i} : ADDR_W'(0);

endmodule

// File: rtl/seg_data_agen.sv
module seg_data_agen
   import dag_pkg::*;
#(
   parameter int PTR_W   = 16,
   parameter int PAGE_W  = 6,
   parameter int IMM_W   = 6,
   parameter int WORD_W  = 16,
   parameter int DS_LSB  = 10,
   parameter bit REG_OUT = 1'b1,
   localparam int ADDR_W = PTR_W + PAGE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          mode_sel,
   input  logic [2:0]          sub_sel,
   input  logic [IMM_W-1:0]    imm6,
   input  logic [PTR_W-1:0]    ext_word,
   input  logic [PTR_W-1:0]    base_ptr,
   input  logic [PTR_W-1:0]    src_ptr,
   input  logic [WORD_W-1:0]   stat_reg,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [PTR_W-1:0]    ptr_next,
   output logic                ptr_we,
   output logic                mem_req
);

   generate
      if (IMM_W > PTR_W) begin : g_bad_imm
         $error("seg_data_agen: immediate wider than pointer");
      end
   endgenerate

   logic [PTR_W-1:0]  step_ea;
   logic [PTR_W-1:0]  step_next;
   logic              step_mod;
   logic [PTR_W-1:0]  ofs_w;
   logic              seg_w;
   logic              ptr_mode_w;
   logic [ADDR_W-1:0] c_addr;
   logic [PTR_W-1:0]  c_next;
   logic              c_we;
   logic              c_req;

   dag_ptr_step #(.PTR_W(PTR_W)) u_step (
      .step_i   (pstep_e'(sub_sel[1:0])),
      .ptr_i    (src_ptr),
      .ea_o     (step_ea),
      .next_o   (step_next),
      .modify_o (step_mod)
   );

   dag_offset_sel #(.PTR_W(PTR_W), .IMM_W(IMM_W)) u_sel (
      .mode_i     (amode_e'(mode_sel)),
      .sub_i      (sub_sel),
      .imm_i      (imm6),
      .ext_i      (ext_word),
      .bp_i       (base_ptr),
      .ptr_ea_i   (step_ea),
      .ofs_o      (ofs_w),
      .mem_o      (c_req),
      .seg_o      (seg_w),
      .ptr_mode_o (ptr_mode_w)
   );

   dag_page_merge #(
      .PTR_W(PTR_W), .PAGE_W(PAGE_W), .WORD_W(WORD_W), .DS_LSB(DS_LSB)
   ) u_merge (
      .seg_i  (seg_w),
      .mem_i  (c_req),
      .stat_i (stat_reg),
      .ofs_i  (ofs_w),
      .addr_o (c_addr)
   );

   assign c_we   = ptr_mode_w & step_mod;
   assign c_next = c_we ? step_next : src_ptr;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mem_addr <= '0;
               ptr_next <= '0;
               ptr_we   <= 1'b0;
               mem_req  <= 1'b0;
            end else begin
               mem_addr <= c_addr;
               ptr_next <= c_next;
               ptr_we   <= c_we;
               mem_req  <= c_req;
            end
         end
      end else begin : g_comb
         assign mem_addr = c_addr;
         assign ptr_next = c_next;
         assign ptr_we   = c_we;
         assign mem_req  = c_req;
      end
   endgenerate

endmodule

// File: rtl/dag_addr_chk.sv
module dag_addr_chk #(
   parameter int PTR_W   = 16,
   parameter int PAGE_W  = 6,
   parameter int WORD_W  = 16,
   parameter int DS_LSB  = 10,
   parameter bit REG_OUT = 1'b1,
   localparam int ADDR_W = PTR_W + PAGE_W
) (
   input logic                clk,
   input logic                rst_n,
   input logic [2:0]          mode_sel,
   input logic [2:0]          sub_sel,
   input logic [PTR_W-1:0]    src_ptr,
   input logic [WORD_W-1:0]   stat_reg,
   input logic [ADDR_W-1:0]   c_addr,
   input logic [PTR_W-1:0]    c_next,
   input logic                c_we,
   input logic                c_req,
   input logic [ADDR_W-1:0]   mem_addr,
   input logic [PTR_W-1:0]    ptr_next,
   input logic                ptr_we,
   input logic                mem_req
);

   logic qual_w;
   assign qual_w = (mode_sel == 3'd3) && sub_sel[2];

   a_r5_ds_page: assert property (@(posedge clk) disable iff (!rst_n)
      qual_w |-> c_addr[ADDR_W-1:PTR_W] == stat_reg[DS_LSB +: PAGE_W]);

   a_r6_page_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !qual_w |-> c_addr[ADDR_W-1:PTR_W] == '0);

   a_r11_we_needs_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      c_we |-> (mode_sel == 3'd3) && (sub_sel[1:0] != 2'd0) && c_req);

   a_r10_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      c_we |-> (c_next == src_ptr + PTR_W'(1)) || (c_next == src_ptr - PTR_W'(1)));

   a_r11_hold_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      !c_we |-> c_next == src_ptr);

   a_r11_idle_addr: assert property (@(posedge clk) disable iff (!rst_n)
      !c_req |-> c_addr == '0);

   generate
      if (REG_OUT) begin : g_lat
         a_r12_one_stage: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (mem_addr == $past(c_addr)) && (ptr_next == $past(c_next))
                     && (ptr_we == $past(c_we)) && (mem_req == $past(c_req)));
      end
   endgenerate

endmodule

bind seg_data_agen dag_addr_chk #(
   .PTR_W(PTR_W), .PAGE_W(PAGE_W), .WORD_W(WORD_W), .DS_LSB(DS_LSB), .REG_OUT(REG_OUT)
) u_dag_chk (
   .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sub_sel(sub_sel),
   .src_ptr(src_ptr), .stat_reg(stat_reg), .c_addr(c_addr), .c_next(c_next),
   .c_we(c_we), .c_req(c_req), .mem_addr(mem_addr), .ptr_next(ptr_next),
   .ptr_we(ptr_we), .mem_req(mem_req)
);

// File: tb/test_seg_data_agen.sv
`timescale 1ns/1ps
module test_seg_data_agen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode_sel = '0;
   logic [2:0]  sub_sel = '0;
   logic [5:0]  imm6 = '0;
   logic [15:0] ext_word = '0;
   logic [15:0] base_ptr = '0;
   logic [15:0] src_ptr = '0;
   logic [15:0] stat_reg = '0;
   logic [21:0] mem_addr;
   logic [15:0] ptr_next;
   logic        ptr_we;
   logic        mem_req;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   seg_data_agen i_seg_data_agen (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sub_sel(sub_sel),
      .imm6(imm6), .ext_word(ext_word), .base_ptr(base_ptr), .src_ptr(src_ptr),
      .stat_reg(stat_reg), .mem_addr(mem_addr), .ptr_next(ptr_next),
      .ptr_we(ptr_we), .mem_req(mem_req)
   );

   task automatic expect_out(string req, logic [21:0] ea, logic [15:0] en,
                             logic ew, logic er);
      n_chk++;
      if (mem_addr !== ea || ptr_next !== en || ptr_we !== ew || mem_req !== er) begin
         n_bad++;
         $display("FAIL %s: got addr=%06h next=%04h we=%b req=%b, expected addr=%06h next=%04h we=%b req=%b",
                  req, mem_addr, ptr_next, ptr_we, mem_req, ea, en, ew, er);
      end
   endtask

   task automatic apply(logic [2:0] m, logic [2:0] s, logic [5:0] im, logic [15:0] ex,
                        logic [15:0] bp, logic [15:0] rs, logic [15:0] sr);
      @(negedge clk);
      mode_sel = m; sub_sel = s; imm6 = im; ext_word = ex;
      base_ptr = bp; src_ptr = rs; stat_reg = sr;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset;
      expect_out("R12 reset", 22'h0, 16'h0, 1'b0, 1'b0);
   endtask

   task automatic t_indirect_plain;
      apply(3'd3, 3'd0, 6'h11, 16'h9999, 16'h0, 16'h1234, 16'hFC00);
      expect_out("R1 plain indirect", 22'h001234, 16'h1234, 1'b0, 1'b1);
   endtask

   task automatic t_steps;
      apply(3'd3, 3'd1, 6'h0, 16'h0, 16'h0, 16'h0100, 16'h0);
      expect_out("R2 post-decrement", 22'h000100, 16'h00FF, 1'b1, 1'b1);
      apply(3'd3, 3'd2, 6'h0, 16'h0, 16'h0, 16'h0200, 16'h0);
      expect_out("R3 post-increment", 22'h000200, 16'h0201, 1'b1, 1'b1);
      apply(3'd3, 3'd3, 6'h0, 16'h0, 16'h0, 16'h0300, 16'h0);
      expect_out("R4 pre-increment", 22'h000301, 16'h0301, 1'b1, 1'b1);
   endtask

   task automatic t_segment;
      apply(3'd3, 3'd6, 6'h0, 16'h0, 16'h0, 16'h4000, 16'h5400);
      expect_out("R5 DS post-increment", 22'h154000, 16'h4001, 1'b1, 1'b1);
      apply(3'd3, 3'd4, 6'h0, 16'h0, 16'h0, 16'hABCD, 16'hFFFF);
      expect_out("R5 DS plain", 22'h3FABCD, 16'hABCD, 1'b0, 1'b1);
      apply(3'd3, 3'd3, 6'h0, 16'h0, 16'h0, 16'h0042, 16'hFFFF);
      expect_out("R6 unqualified ignores DS", 22'h000043, 16'h0043, 1'b1, 1'b1);
   endtask

   task automatic t_wrap;
      apply(3'd3, 3'd7, 6'h0, 16'h0, 16'h0, 16'hFFFF, 16'h5400);
      expect_out("R10 pre-increment wrap", 22'h150000, 16'h0000, 1'b1, 1'b1);
      apply(3'd3, 3'd5, 6'h0, 16'h0, 16'h0, 16'h0000, 16'h5400);
      expect_out("R10 post-decrement wrap", 22'h150000, 16'hFFFF, 1'b1, 1'b1);
      apply(3'd3, 3'd2, 6'h0, 16'h0, 16'h0, 16'hFFFF, 16'h0);
      expect_out("R10 post-increment wrap", 22'h00FFFF, 16'h0000, 1'b1, 1'b1);
   endtask

   task automatic t_base_direct;
      apply(3'd0, 3'd5, 6'h3F, 16'h0, 16'h1000, 16'h7777, 16'hFC00);
      expect_out("R7 base plus offset", 22'h00103F, 16'h7777, 1'b0, 1'b1);
      apply(3'd0, 3'd0, 6'h20, 16'h0, 16'hFFF0, 16'h0001, 16'hFC00);
      expect_out("R7 base offset wrap", 22'h000010, 16'h0001, 1'b0, 1'b1);
      apply(3'd7, 3'd6, 6'h2A, 16'h0, 16'h1000, 16'h0002, 16'hFC00);
      expect_out("R8 direct immediate", 22'h00002A, 16'h0002, 1'b0, 1'b1);
   endtask

   task automatic t_ext;
      apply(3'd4, 3'd2, 6'h0, 16'hBEEF, 16'h0, 16'h0003, 16'hFC00);
      expect_out("R9 load second word", 22'h00BEEF, 16'h0003, 1'b0, 1'b1);
      apply(3'd4, 3'd3, 6'h0, 16'h0001, 16'h0, 16'h0004, 16'hFC00);
      expect_out("R9 store second word", 22'h000001, 16'h0004, 1'b0, 1'b1);
      apply(3'd4, 3'd0, 6'h0, 16'hBEEF, 16'h0, 16'h0005, 16'hFC00);
      expect_out("R9 register form not memory", 22'h0, 16'h0005, 1'b0, 1'b0);
   endtask

   task automatic t_nonmem;
      for (int m = 1; m <= 6; m++) begin
         if (m == 3 || m == 4) continue;
         apply(3'(m), 3'd2, 6'h15, 16'h1111, 16'h2222, 16'h3333, 16'hFC00);
         expect_out("R11 non-memory mode", 22'h0, 16'h3333, 1'b0, 1'b0);
      end
   endtask

   task automatic t_latency;
      apply(3'd7, 3'd0, 6'h05, 16'h0, 16'h0, 16'h0, 16'h0);
      @(negedge clk);
      imm6 = 6'h06;
      #1;
      expect_out("R12 holds until edge", 22'h000005, 16'h0000, 1'b0, 1'b1);
      @(posedge clk);
      #1;
      expect_out("R12 updates after edge", 22'h000006, 16'h0000, 1'b0, 1'b1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_indirect_plain();
      t_steps();
      t_segment();
      t_wrap();
      t_base_direct();
      t_ext();
      t_nonmem();
      t_latency();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule